// File: doc/BRIEF.md
# Seven-Phase Instruction Sequencer

This block is the phase controller of a small 16-bit processor that spends exactly seven clock cycles on every instruction. It steps through a fixed cycle and emits one strobe per phase for the datapath. The first phase captures the instruction word. The next two advance the instruction counter: the counter plus one goes into an accumulator, and the accumulator is then copied back into the counter. The fourth phase captures the data word that follows the instruction. The fifth enables execution. The last two advance the counter once more, past the data word.

Decoding and the datapath itself sit outside this block. The sequencer only decides which phase is active. It also handles two requests from the decoder. A halt request seen during execution freezes the machine until reset. A taken-jump indication seen during execution blanks the two counter-advance phases that follow, so the counter value written by the jump is not overwritten.

All strobes and the halted flag come straight from flip-flops. The reset is synchronous and active high. Clearing the external instruction counter is not this block's job.

Top module: `seq_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ir_load_o` is 1 and all other strobes and `halted_o` are 0.
- R2: With no halt or jump, the strobes repeat with a period of seven cycles in this order: `ir_load_o`, `ic_inc_o`, `ic_copy_o`, `idr_load_o`, `exec_o`, `ic_inc_o`, `ic_copy_o`.
- R3: At most one of the five strobes is 1 in any cycle. Exactly one is 1 in every cycle that is neither halted nor a blanked counter phase.
- R4: If `halt_i` is 1 on a clock edge that ends an `exec_o` cycle, `halted_o` is 1 from the next cycle on and all five strobes stay 0 until reset.
- R5: `halt_i` has no effect in any cycle where `exec_o` is 0.
- R6: If `jump_i` is 1 and `halt_i` is 0 at the end of an `exec_o` cycle, the next two cycles have all strobes 0, and `ir_load_o` follows them.
- R7: `jump_i` has no effect in any cycle where `exec_o` is 0.
- R8: Asserting reset while halted clears `halted_o` and restarts the sequence at the `ir_load_o` phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt request from the decoder, sampled only in the execute phase |
| jump_i | input | 1 | Jump-taken indication, sampled only in the execute phase |
| ir_load_o | output | 1 | Capture the instruction word into the instruction register |
| ic_inc_o | output | 1 | Write the counter plus one into the counter accumulator |
| ic_copy_o | output | 1 | Copy the counter accumulator into the instruction counter |
| idr_load_o | output | 1 | Capture the data word into the instruction data register |
| exec_o | output | 1 | Execute enable for the decoders |
| halted_o | output | 1 | Machine is frozen after a halt |

## Verification
The hardest cases are the two requests that only count in the single execute cycle out of seven: a halt or jump arriving on any other phase must be ignored. Random stimulus raises `jump_i` often and `halt_i` rarely in every phase, so both requests land in the execute cycle and in all the other phases many times. A reset follows each halt so the run continues. Directed sequences then place each request exactly one phase before and at the execute phase, and restart from the halted state through reset.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NUM_PHASES = 7;
  localparam int PH_W       = $clog2(NUM_PHASES);
  localparam int NUM_STB    = 5;

  typedef logic [PH_W-1:0] phase_t;

  // phase numbers; the order is the behaviour
  localparam phase_t PH_FETCH = phase_t'(0);
  localparam phase_t PH_INC_A = phase_t'(1);
  localparam phase_t PH_CPY_A = phase_t'(2);
  localparam phase_t PH_DATA  = phase_t'(3);
  localparam phase_t PH_EXEC  = phase_t'(4);
  localparam phase_t PH_INC_B = phase_t'(5);
  localparam phase_t PH_CPY_B = phase_t'(6);
  localparam phase_t PH_LAST  = phase_t'(NUM_PHASES-1);

  // strobe bit positions
  localparam int SB_IR   = 0;
  localparam int SB_INC  = 1;
  localparam int SB_CPY  = 2;
  localparam int SB_IDR  = 3;
  localparam int SB_EXEC = 4;
endpackage

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   halt_req,
  input  logic   jump_req,
  output phase_t ph_d,
  output logic   halt_d,
  output logic   skip_d
);
  phase_t ph_q;
  logic   halt_q;
  logic   skip_q;

  always_comb begin
    ph_d   = ph_q;
    halt_d = halt_q;
    skip_d = skip_q;
    if (!halt_q) begin
      if (ph_q == PH_EXEC && halt_req) begin
        halt_d = 1'b1;
      end else begin
        if (ph_q == PH_EXEC && jump_req) skip_d = 1'b1;
        if (ph_q == PH_LAST) begin
          ph_d   = PH_FETCH;
          skip_d = 1'b0;
        end else begin
          ph_d = ph_q + phase_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_FETCH;
      halt_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      halt_q <= halt_d;
      skip_q <= skip_d;
    end
  end
endmodule

// File: rtl/seq_strobe_reg.sv
module seq_strobe_reg
  import seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  phase_t             ph_d,
  input  logic               halt_d,
  input  logic               skip_d,
  output logic [NUM_STB-1:0] stb_q,
  output logic               halted_q
);
  logic [NUM_STB-1:0] stb_d;

  always_comb begin
    stb_d = '0;
    if (!halt_d) begin
      unique case (ph_d)
        PH_FETCH:           stb_d[SB_IR]   = 1'b1;
        PH_INC_A:           stb_d[SB_INC]  = 1'b1;
        PH_CPY_A:           stb_d[SB_CPY]  = 1'b1;
        PH_DATA:            stb_d[SB_IDR]  = 1'b1;
        PH_EXEC:            stb_d[SB_EXEC] = 1'b1;
        PH_INC_B:           stb_d[SB_INC]  = !skip_d;
        PH_CPY_B:           stb_d[SB_CPY]  = !skip_d;
        default:            stb_d          = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q    <= NUM_STB'(1) << SB_IR;
      halted_q <= 1'b0;
    end else begin
      stb_q    <= stb_d;
      halted_q <= halt_d;
    end
  end
endmodule

// File: rtl/seq_sequencer.sv
module seq_sequencer
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_i,
  input  logic jump_i,
  output logic ir_load_o,
  output logic ic_inc_o,
  output logic ic_copy_o,
  output logic idr_load_o,
  output logic exec_o,
  output logic halted_o
);
  phase_t             ph_d;
  logic               halt_d;
  logic               skip_d;
  logic [NUM_STB-1:0] stb;

  seq_phase_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .halt_req (halt_i),
    .jump_req (jump_i),
    .ph_d     (ph_d),
    .halt_d   (halt_d),
    .skip_d   (skip_d)
  );

  seq_strobe_reg u_stb (
    .clk      (clk),
    .rst      (rst),
    .ph_d     (ph_d),
    .halt_d   (halt_d),
    .skip_d   (skip_d),
    .stb_q    (stb),
    .halted_q (halted_o)
  );

  assign ir_load_o  = stb[SB_IR];
  assign ic_inc_o   = stb[SB_INC];
  assign ic_copy_o  = stb[SB_CPY];
  assign idr_load_o = stb[SB_IDR];
  assign exec_o     = stb[SB_EXEC];
endmodule

// File: rtl/seq_sequencer_chk.sv
module seq_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic halt_i,
  input logic jump_i,
  input logic ir_load_o,
  input logic ic_inc_o,
  input logic ic_copy_o,
  input logic idr_load_o,
  input logic exec_o,
  input logic halted_o
);
  logic [4:0] vec;
  assign vec = {exec_o, idr_load_o, ic_copy_o, ic_inc_o, ir_load_o};

  // R3
  stb_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(vec));
  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ir_load_o && !halted_o);
  // R2
  fetch_to_inc_chk: assert property (@(posedge clk) disable iff (rst) ir_load_o |=> ic_inc_o);
  // R2
  inc_to_copy_chk: assert property (@(posedge clk) disable iff (rst) ic_inc_o |=> ic_copy_o);
  // R2
  data_to_exec_chk: assert property (@(posedge clk) disable iff (rst) idr_load_o |=> exec_o);
  // R4
  halt_enter_chk: assert property (@(posedge clk) disable iff (rst) exec_o && halt_i |=> halted_o);
  // R4
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst) halted_o |=> halted_o);
  // R4
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) halted_o |-> vec == 5'b0);
  // R5
  halt_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !exec_o && !halted_o && halt_i |=> !halted_o);
  // R6
  jump_blank_chk: assert property (@(posedge clk) disable iff (rst)
    exec_o && jump_i && !halt_i |=> vec == 5'b0);
endmodule

bind seq_sequencer seq_sequencer_chk u_chk (.*);

// File: tb/tb_seq_sequencer.sv
module tb_seq_sequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_i = 1'b0;
  logic jump_i = 1'b0;
  logic ir_load_o, ic_inc_o, ic_copy_o, idr_load_o, exec_o, halted_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  int es = 0;
  bit eh = 0;
  bit ek = 0;
  bit after_rst = 1;
  string tag_next = "";

  always #10 clk = ~clk;

  seq_sequencer dut (
    .clk(clk), .rst(rst), .halt_i(halt_i), .jump_i(jump_i),
    .ir_load_o(ir_load_o), .ic_inc_o(ic_inc_o), .ic_copy_o(ic_copy_o),
    .idr_load_o(idr_load_o), .exec_o(exec_o), .halted_o(halted_o)
  );

  // {ir, inc, copy, idr, exec, halted}
  function automatic logic [5:0] expect_vec(int s, bit h, bit k);
    if (h) return 6'b000001;
    case (s)
      0: return 6'b100000;
      1: return 6'b010000;
      2: return 6'b001000;
      3: return 6'b000100;
      4: return 6'b000010;
      5: return k ? 6'b000000 : 6'b010000;
      6: return k ? 6'b000000 : 6'b001000;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string auto_tag(int s, bit h, bit k, bit ar);
    if (ar) return "R1";
    if (h) return "R4";
    if (k && s >= 5) return "R6";
    return "R2";
  endfunction

  task automatic check_now();
    logic [5:0] act, exp;
    string t;
    act = {ir_load_o, ic_inc_o, ic_copy_o, idr_load_o, exec_o, halted_o};
    exp = expect_vec(es, eh, ek);
    t = (tag_next != "") ? tag_next : auto_tag(es, eh, ek, after_rst);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: outputs %b expected %b (phase %0d)", t, act, exp, es);
    end
    // R3: strobe count
    if (!eh && !(ek && es >= 5)) begin
      total++;
      if ($countones(act[5:1]) != 1) begin
        bad++;
        $display("FAIL R3: strobes %b expected exactly one high", act[5:1]);
      end
    end
    tag_next = "";
  endtask

  // check current cycle, then drive inputs for the next edge and advance model
  task automatic cyc(input bit r, input bit h, input bit j, input string t);
    @(negedge clk);
    check_now();
    rst = r; halt_i = h; jump_i = j;
    tag_next = t;
    after_rst = r;
    if (r) begin
      es = 0; eh = 0; ek = 0;
    end else if (!eh) begin
      if (es == 4 && h) eh = 1;
      else begin
        if (es == 4 && j) ek = 1;
        if (es == 6) begin es = 0; ek = 0; end
        else es = es + 1;
      end
    end
  endtask

  task automatic goto_phase(int p);
    while (es != p || eh) cyc(eh, 0, 0, "");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    cyc(1, 0, 0, "R1");
    cyc(0, 0, 0, "R1");
    // R2: two plain instructions
    repeat (14) cyc(0, 0, 0, "R2");
    // R5: halt one phase before execute and after it
    goto_phase(3);
    cyc(0, 1, 0, "R5");
    goto_phase(5);
    cyc(0, 1, 0, "R5");
    // R7: jump outside execute
    goto_phase(3);
    cyc(0, 0, 1, "R7");
    goto_phase(6);
    cyc(0, 0, 1, "R7");
    // R6: jump at execute
    goto_phase(4);
    cyc(0, 0, 1, "R6");
    repeat (3) cyc(0, 0, 0, "");
    // R4: halt at execute with jump too
    goto_phase(4);
    cyc(0, 1, 1, "R4");
    repeat (5) cyc(0, 1, 1, "R4");
    // R8: reset from halted
    cyc(1, 0, 0, "R8");
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 0, "R8");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit h, j, r;
      h = ($urandom % 30) == 0;
      j = ($urandom % 3) == 0;
      r = eh && (($urandom % 6) == 0);
      cyc(r, h, j, "");
    end
    cyc(0, 0, 0, "");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule